// File: doc/BRIEF.md
# Processor Power-Gate Sequencer

This block wakes a processor that sleeps with its program memory retained, and puts it back to sleep. A wake request turns on the enables of several switched supply domains, one of which is the domain that generates the processor clock. The block then waits for every switch to acknowledge. Only after that does it let the processor fetch code that is already held in the always-on memory. When software raises the end-of-computation line, the block first withdraws fetch permission. It then drops the domain enables and waits for every acknowledge to clear before it reports sleep again.

The acknowledge lines and the end-of-computation line come from other clock or analog domains, so they are resynchronised inside the block. Each handshake wait is bounded by a limit that software supplies. A handshake that never completes sets a sticky error flag and sends the block back towards sleep. A wake request that arrives while a power cycle is already in progress is remembered and served as soon as the block returns to sleep.

Top module: `pgate_seq`

## Requirements
- R1: While reset is asserted and immediately after it, every domain enable, fetch permission and the error flag are low.
- R2: A wake request seen high at a rising edge while the block sleeps raises all domain enables together on that edge.
- R3: Fetch permission rises only while all domain enables are high. It rises on the third rising edge at which every acknowledge input reads high. An acknowledge that arrives late on any one domain delays it.
- R4: Fetch permission falls on the third rising edge at which the end-of-computation input reads high. The domain enables fall one edge later.
- R5: The retention supply enable output is high in every state, including reset.
- R6: After the enables drop, the block counts as asleep only from the third rising edge at which every acknowledge reads low. No new power-up starts before then.
- R7: Each handshake wait has a timeout. If the wait has not completed after ackLimit+1 cycles in the wait state, the error flag rises. During power-up the enables drop and the block goes to power-down. During power-down the block goes straight to sleep.
- R8: The error flag stays high until the next power-up begins, and is cleared on that edge.
- R9: A wake request that arrives while the block is not asleep is stored. It starts a new power-up on the first edge after the block is asleep again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wakeReq | input | 1 | Wake request, synchronous to clk |
| ackLimit | input | CNT_W | Timeout for each handshake wait, in cycles |
| gateAck | input | NDOM | Per-domain switch acknowledge, asynchronous |
| eocIn | input | 1 | End-of-computation from the processor, asynchronous |
| gateEn | output | NDOM | Per-domain power-switch enables |
| fetchEn | output | 1 | Fetch permission to the processor |
| retainPwrEn | output | 1 | Enable of the retained memory supply, always high |
| gateErr | output | 1 | Sticky handshake timeout flag |

## Verification
A behavioural model is compared with the design on every cycle while the scenarios below run.
- A balanced acknowledge and an uneven one (one domain much slower) show that fetch waits for the slowest switch and not the first.
- A wake during a run and a wake during a slow power-down separate a stored request from one that is lost or served too early.
- An acknowledge stuck low during power-up, and one stuck high during power-down, exercise the two timeout paths.
- The same scenarios show that the error clears on the following power-up.

// File: rtl/pgate_pkg.sv
package pgate_pkg;

  typedef enum logic [2:0] {
    PS_SLEEP = 3'd0,
    PS_RAMP  = 3'd1,
    PS_RUN   = 3'd2,
    PS_HALT  = 3'd3,
    PS_DRAIN = 3'd4
  } pwrState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic gateOn;
    logic gateOff;
    logic fetchOn;
    logic fetchOff;
    logic cntClr;
    logic errSet;
    logic errClr;
    logic pendSet;
    logic pendClr;
  } seqStrobe_t;

endpackage

// File: rtl/pgate_sync.sv
module pgate_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/pgate_ctrl.sv
module pgate_ctrl
  import pgate_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wakeReq,
  input  logic       pending,
  input  logic       ackAll,
  input  logic       ackNone,
  input  logic       eocSeen,
  input  logic       tmoHit,
  output seqStrobe_t stb
);

  pwrState_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PS_SLEEP;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    stb      = '0;
    unique case (state)
      PS_SLEEP: begin
        if (wakeReq || pending) begin
          stateNxt    = PS_RAMP;
          stb.gateOn  = 1'b1;
          stb.cntClr  = 1'b1;
          stb.errClr  = 1'b1;
          stb.pendClr = 1'b1;
        end
      end
      PS_RAMP: begin
        if (ackAll) begin
          stateNxt    = PS_RUN;
          stb.fetchOn = 1'b1;
        end else if (tmoHit) begin
          stateNxt    = PS_DRAIN;
          stb.gateOff = 1'b1;
          stb.cntClr  = 1'b1;
          stb.errSet  = 1'b1;
        end
      end
      PS_RUN: begin
        if (eocSeen) begin
          stateNxt     = PS_HALT;
          stb.fetchOff = 1'b1;
        end
      end
      PS_HALT: begin
        stateNxt    = PS_DRAIN;
        stb.gateOff = 1'b1;
        stb.cntClr  = 1'b1;
      end
      PS_DRAIN: begin
        if (ackNone) begin
          stateNxt = PS_SLEEP;
        end else if (tmoHit) begin
          stateNxt   = PS_SLEEP;
          stb.errSet = 1'b1;
        end
      end
      default: stateNxt = PS_SLEEP;
    endcase
    if (wakeReq && (state != PS_SLEEP)) stb.pendSet = 1'b1;
  end

endmodule

// File: rtl/pgate_dp.sv
module pgate_dp
  import pgate_pkg::*;
#(
  parameter int NDOM  = 2,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       stb,
  input  logic [CNT_W-1:0] ackLimit,
  output logic [NDOM-1:0]  gateEn,
  output logic             fetchEn,
  output logic             gateErr,
  output logic             pending,
  output logic             tmoHit
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] waitCnt;

  for (genvar d = 0; d < NDOM; d++) begin : g_dom
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           gateEn[d] <= 1'b0;
      else if (stb.gateOn) gateEn[d] <= 1'b1;
      else if (stb.gateOff) gateEn[d] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             fetchEn <= 1'b0;
    else if (stb.fetchOn)  fetchEn <= 1'b1;
    else if (stb.fetchOff) fetchEn <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            waitCnt <= '0;
    else if (stb.cntClr)  waitCnt <= '0;
    else if (waitCnt != CNT_MAX) waitCnt <= waitCnt + 1'b1;
  end

  assign tmoHit = (waitCnt >= ackLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           gateErr <= 1'b0;
    else if (stb.errClr) gateErr <= 1'b0;
    else if (stb.errSet) gateErr <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            pending <= 1'b0;
    else if (stb.pendSet) pending <= 1'b1;
    else if (stb.pendClr) pending <= 1'b0;
  end

endmodule

// File: rtl/pgate_seq.sv
module pgate_seq
  import pgate_pkg::*;
#(
  parameter int NDOM        = 2,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wakeReq,
  input  logic [CNT_W-1:0] ackLimit,
  input  logic [NDOM-1:0]  gateAck,
  input  logic             eocIn,
  output logic [NDOM-1:0]  gateEn,
  output logic             fetchEn,
  output logic             retainPwrEn,
  output logic             gateErr
);

  localparam int SW = NDOM + 1;

  logic [SW-1:0] syncIn, syncOut;
  logic [NDOM-1:0] ackSync;
  logic eocSync, pending, tmoHit;
  seqStrobe_t stb;

  assign syncIn  = {eocIn, gateAck};
  assign ackSync = syncOut[NDOM-1:0];
  assign eocSync = syncOut[NDOM];

  pgate_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .din(syncIn), .dout(syncOut)
  );

  pgate_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wakeReq(wakeReq), .pending(pending),
    .ackAll(&ackSync), .ackNone(~|ackSync), .eocSeen(eocSync),
    .tmoHit(tmoHit), .stb(stb)
  );

  pgate_dp #(.NDOM(NDOM), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .ackLimit(ackLimit),
    .gateEn(gateEn), .fetchEn(fetchEn), .gateErr(gateErr),
    .pending(pending), .tmoHit(tmoHit)
  );

  assign retainPwrEn = 1'b1;

endmodule

// File: rtl/pgate_seq_chk.sv
module pgate_seq_chk #(
  parameter int NDOM = 2
) (
  input logic            clk,
  input logic            rstN,
  input logic [NDOM-1:0] gateEn,
  input logic            fetchEn,
  input logic            gateErr
);

  // R3
  fetch_needs_gates_chk: assert property (@(posedge clk) disable iff (!rstN)
    fetchEn |-> (&gateEn));

  // R3
  fetch_rise_late_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fetchEn) |-> $past(&gateEn));

  // R4
  gates_outlast_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fetchEn) |-> (&gateEn));

  // R2
  gates_together_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|gateEn) |-> (&gateEn));

  // R7
  err_without_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateErr) |-> !fetchEn);

endmodule

bind pgate_seq pgate_seq_chk #(.NDOM(NDOM)) u_chk (
  .clk(clk), .rstN(rstN), .gateEn(gateEn), .fetchEn(fetchEn), .gateErr(gateErr)
);

// File: tb/pgate_seq_bench.sv
module pgate_seq_bench;

  localparam int NDOM = 2;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wakeReq = 1'b0;
  logic [CNT_W-1:0] ackLimit = 16'd40;
  logic [NDOM-1:0] gateAck = '0;
  logic eocIn = 1'b0;
  logic [NDOM-1:0] gateEn;
  logic fetchEn, retainPwrEn, gateErr;

  int total = 0;
  int bad = 0;
  int fetchRises = 0;
  logic fetchPrev = 1'b0;

  always #4 clk = ~clk;

  pgate_seq u_pgate_seq (
    .clk(clk), .rstN(rstN), .wakeReq(wakeReq), .ackLimit(ackLimit),
    .gateAck(gateAck), .eocIn(eocIn), .gateEn(gateEn), .fetchEn(fetchEn),
    .retainPwrEn(retainPwrEn), .gateErr(gateErr)
  );

  // external switch responder: mode 0 delayed echo, 1 stuck low, 2 stuck high
  int ackDly [NDOM];
  int ackMode [NDOM];
  logic [31:0] ackHist [NDOM];

  initial begin
    for (int d = 0; d < NDOM; d++) begin
      ackDly[d] = 2; ackMode[d] = 0; ackHist[d] = '0;
    end
  end

  always @(negedge clk) begin
    for (int d = 0; d < NDOM; d++) begin
      ackHist[d] = {ackHist[d][30:0], gateEn[d]};
      case (ackMode[d])
        0: gateAck[d] = ackHist[d][ackDly[d]];
        1: gateAck[d] = 1'b0;
        default: gateAck[d] = 1'b1;
      endcase
    end
  end

  // behavioural reference
  int mState, mOld, mCnt;
  bit mPend, mErr, mStart, mClr, mSetE;
  logic [NDOM-1:0] mA1, mA2;
  bit mE1, mE2;

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mCnt = 0; mPend = 0; mErr = 0;
      mA1 = '0; mA2 = '0; mE1 = 0; mE2 = 0;
    end else begin
      mOld = mState; mStart = 0; mClr = 0; mSetE = 0;
      case (mState)
        0: if (wakeReq || mPend) begin mState = 1; mStart = 1; mClr = 1; end
        1: if (&mA2) mState = 2;
           else if (mCnt >= int'(ackLimit)) begin mState = 4; mClr = 1; mSetE = 1; end
        2: if (mE2) mState = 3;
        3: begin mState = 4; mClr = 1; end
        default: if (mA2 == '0) mState = 0;
                 else if (mCnt >= int'(ackLimit)) begin mState = 0; mSetE = 1; end
      endcase
      if (wakeReq && mOld != 0) mPend = 1;
      else if (mStart) mPend = 0;
      if (mStart) mErr = 0;
      else if (mSetE) mErr = 1;
      if (mClr) mCnt = 0;
      else if (mCnt < 65535) mCnt = mCnt + 1;
      mA2 = mA1; mA1 = gateAck; mE2 = mE1; mE1 = eocIn;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison
  always @(negedge clk) begin
    bit eg, ef;
    eg = (mState >= 1 && mState <= 3);
    ef = (mState == 2);
    check("R2 gateEn vs model", 32'(gateEn), eg ? 32'(3) : 32'(0));
    check("R3 fetchEn vs model", 32'(fetchEn), 32'(ef));
    check("R7 gateErr vs model", 32'(gateErr), 32'(mErr));
    check("R5 retainPwrEn", 32'(retainPwrEn), 32'(1));
    if (fetchEn && !fetchPrev) fetchRises++;
    fetchPrev = fetchEn;
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wake();
    @(negedge clk); wakeReq = 1'b1;
    @(negedge clk); wakeReq = 1'b0;
  endtask

  task automatic waitFetch(input int lim);
    for (int i = 0; i < lim && !fetchEn; i++) @(negedge clk);
  endtask

  task automatic waitSleep(input int lim);
    for (int i = 0; i < lim && gateEn != '0; i++) @(negedge clk);
    cyc(10);
  endtask

  task automatic runTests();
    cyc(3);
    // R1 reset state
    check("R1 gateEn in reset", 32'(gateEn), 0);
    check("R1 fetchEn in reset", 32'(fetchEn), 0);
    check("R5 retain in reset", 32'(retainPwrEn), 1);
    @(negedge clk); rstN = 1'b1;
    cyc(2);
    check("R1 gateErr after reset", 32'(gateErr), 0);

    // balanced acknowledge, timed end-of-computation
    wake();
    waitFetch(50);
    check("R3 fetch reached", 32'(fetchEn), 1);
    cyc(5);
    @(negedge clk); eocIn = 1'b1;
    @(negedge clk); eocIn = 1'b0;
    cyc(1);
    check("R4 fetch still high before 3rd edge", 32'(fetchEn), 1);
    @(negedge clk);
    check("R4 fetch low on 3rd edge", 32'(fetchEn), 0);
    check("R4 gates still on", 32'(gateEn), 3);
    @(negedge clk);
    check("R4 gates off one edge later", 32'(gateEn), 0);
    waitSleep(60);

    // uneven acknowledge: domain 1 slow
    ackDly[1] = 12;
    wake();
    cyc(8);
    check("R3 fetch waits slow domain", 32'(fetchEn), 0);
    waitFetch(50);
    check("R3 fetch after slow domain", 32'(fetchEn), 1);
    @(negedge clk); eocIn = 1'b1;
    @(negedge clk); eocIn = 1'b0;
    waitSleep(80);
    ackDly[1] = 2;

    // wake during run is stored
    fetchRises = 0;
    wake();
    waitFetch(50);
    wake();
    cyc(4);
    @(negedge clk); eocIn = 1'b1;
    @(negedge clk); eocIn = 1'b0;
    cyc(30);
    check("R9 pending wake served", 32'(fetchEn), 1);
    @(negedge clk); eocIn = 1'b1;
    @(negedge clk); eocIn = 1'b0;
    waitSleep(60);
    check("R9 two power-ups", 32'(fetchRises), 2);

    // wake during slow power-down
    ackDly[0] = 15;
    fetchRises = 0;
    wake();
    waitFetch(60);
    @(negedge clk); eocIn = 1'b1;
    @(negedge clk); eocIn = 1'b0;
    for (int i = 0; i < 20 && gateEn != '0; i++) @(negedge clk);
    wake();
    cyc(3);
    check("R6 no restart while acks high", 32'(gateEn), 0);
    waitFetch(80);
    check("R6 deferred wake served", 32'(fetchRises), 1);
    @(negedge clk); eocIn = 1'b1;
    @(negedge clk); eocIn = 1'b0;
    waitSleep(80);
    ackDly[0] = 2;

    // stuck-low acknowledge on power-up
    ackLimit = 16'd8;
    ackMode[1] = 1;
    wake();
    cyc(30);
    check("R7 error on power-up timeout", 32'(gateErr), 1);
    check("R7 gates dropped", 32'(gateEn), 0);
    cyc(20);
    check("R8 error sticky", 32'(gateErr), 1);
    ackMode[1] = 0;
    wake();
    cyc(1);
    check("R8 error cleared on power-up", 32'(gateErr), 0);
    waitFetch(50);
    @(negedge clk); eocIn = 1'b1;
    @(negedge clk); eocIn = 1'b0;
    waitSleep(60);

    // stuck-high acknowledge on power-down
    ackMode[0] = 2;
    wake();
    waitFetch(50);
    @(negedge clk); eocIn = 1'b1;
    @(negedge clk); eocIn = 1'b0;
    cyc(30);
    check("R7 error on power-down timeout", 32'(gateErr), 1);
    ackMode[0] = 0;
    cyc(10);
  endtask

  initial begin
    fork
      runTests();
      begin
        cyc(20000);
        bad++; total++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule